// File: doc/BRIEF.md
# Sync Polarity and Video Blanking Conditioner

This block sits between a display timing generator and the DAC/connector. It takes raw, active-high horizontal sync, vertical sync and data-enable signals together with a parallel RGB pixel, and produces the signals that actually leave the chip. It can invert each sync on its own, hold each sync at its inactive level, or hold both there at once. It can force the video to black, and it can raise a composite flag that tells the DAC to put sync on the colour channels.

Software sets all of this through two small registers on a simple write/read bus. The display power states are combinations of these bits. Standby holds horizontal sync idle. Suspend holds vertical sync idle. Power-down holds both idle through the global sync-off bit. In every one of these states the picture is also blanked. All outputs are registered, so they stay aligned with one another, one pixel clock behind the raw inputs.

Top module: `sync_cond_stage`

## Requirements
- R1: While reset is asserted on a clock edge, both conditioned syncs, the pixel output and the composite flag are 0 after that edge, and both registers read back as 0.
- R2: `bus_sel`=0 addresses the sync control register and `bus_sel`=1 the display control register. Only bits 0, 1, 3, 4, 5 and 6 of sync control are stored (mask 0x7B). Only bit 1 of display control is stored (mask 0x02). All other bits read as 0. `bus_rdata` shows the addressed register without delay.
- R3: Each output reflects the raw inputs sampled on the previous clock edge: exactly one cycle of latency.
- R4: Sync control bit 3 inverts the horizontal sync output and bit 4 inverts the vertical sync output.
- R5: Sync control bit 5 holds the horizontal sync at its inactive level, which is the value of bit 3. Vertical sync is not affected.
- R6: Sync control bit 6 holds the vertical sync at its inactive level, which is the value of bit 4. Horizontal sync is not affected.
- R7: Sync control bit 1 holds both syncs at their inactive levels (bit 3 and bit 4 respectively), whatever bits 5 and 6 hold.
- R8: The pixel output is all zeros when display control bit 1 is set or when the sampled data-enable is low. Otherwise it equals the sampled pixel.
- R9: When sync control bit 0 is set, the composite flag is 1 when either raw sync that is not suppressed is high. When bit 0 is clear the flag is 0.
- R10: A register write on clock edge k governs the outputs produced on edge k+1. Outputs produced on edge k still use the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 sync control, 1 display control |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data of the selected register |
| raw_hsync | input | 1 | Horizontal sync from timing generator, active high |
| raw_vsync | input | 1 | Vertical sync from timing generator, active high |
| raw_de | input | 1 | Active-video enable |
| pix_in | input | 3*CW | RGB pixel in |
| hsync_out | output | 1 | Conditioned horizontal sync |
| vsync_out | output | 1 | Conditioned vertical sync |
| pix_out | output | 3*CW | Blanked RGB pixel |
| sync_on_rgb | output | 1 | Composite sync flag for the colour channels |

## Verification
The hardest case to reach is a register write that lands on the same edge as a sync transition. In that cycle the old and new configuration give different outputs, and only exact one-cycle alignment separates them. The stimulus reaches it in a phase that writes a fresh random configuration on every clock while the raw syncs and data-enable toggle randomly. Every sampled output then depends on which register value was live at that edge. A per-cycle reference model checks the result.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;

    localparam int REG_W      = 8;
    localparam int SC_SOG     = 0;
    localparam int SC_ALLOFF  = 1;
    localparam int SC_HINV    = 3;
    localparam int SC_VINV    = 4;
    localparam int SC_HOFF    = 5;
    localparam int SC_VOFF    = 6;
    localparam int DC_BLANK   = 1;
    localparam logic [REG_W-1:0] SC_MASK = 8'h7B;
    localparam logic [REG_W-1:0] DC_MASK = 8'h02;
    localparam int NUM_CH     = 2;
    localparam int CH_H       = 0;
    localparam int CH_V       = 1;

    typedef enum logic {
        SEL_SYNC = 1'b0,
        SEL_DISP = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic sog;
        logic all_off;
        logic h_inv;
        logic v_inv;
        logic h_off;
        logic v_off;
    } sync_cfg_t;

    function automatic sync_cfg_t decode_sync(input logic [REG_W-1:0] r);
        sync_cfg_t c;
        c.sog     = r[SC_SOG];
        c.all_off = r[SC_ALLOFF];
        c.h_inv   = r[SC_HINV];
        c.v_inv   = r[SC_VINV];
        c.h_off   = r[SC_HOFF];
        c.v_off   = r[SC_VOFF];
        return c;
    endfunction

    function automatic logic drive_level(input logic raw, input logic inv,
                                         input logic kill);
        return kill ? inv : (raw ^ inv);
    endfunction

endpackage

// File: rtl/sync_cond_regs.sv
module sync_cond_regs
    import sync_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output sync_cfg_t        cfg,
    output logic             blank
);
    logic [REG_W-1:0] sync_q;
    logic [REG_W-1:0] disp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            disp_q <= '0;
        end else if (we) begin
            if (reg_sel_e'(sel) == SEL_DISP)
                disp_q <= wdata & DC_MASK;
            else
                sync_q <= wdata & SC_MASK;
        end
    end

    always_comb begin
        rdata = (reg_sel_e'(sel) == SEL_DISP) ? disp_q : sync_q;
        cfg   = decode_sync(sync_q);
        blank = disp_q[DC_BLANK];
    end

    assert_disp_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && sel) |=> (blank == $past(wdata[DC_BLANK])));

    assert_sync_write_R10: assert property (@(posedge clk) disable iff (rst)
        (we && !sel) |=> (cfg.all_off == $past(wdata[SC_ALLOFF])));

endmodule

// File: rtl/sync_cond_chan.sv
module sync_cond_chan
    import sync_cond_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic inv,
    input  logic kill,
    output logic out_q
);
    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= drive_level(raw, inv, kill);
    end

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
        kill |=> (out_q == $past(inv)));

    assert_follow_raw_R3: assert property (@(posedge clk) disable iff (rst)
        (!kill && !inv) |=> (out_q == $past(raw)));

endmodule

// File: rtl/sync_cond_video.sv
module sync_cond_video #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          de,
    input  logic [3*CW-1:0] pix,
    input  logic          blank,
    input  logic          sog_en,
    input  logic          h_live,
    input  logic          v_live,
    output logic [3*CW-1:0] pix_q,
    output logic          csync_q
);
    localparam int PW = 3 * CW;

    logic show;
    assign show = de && !blank;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q   <= '0;
            csync_q <= 1'b0;
        end else begin
            pix_q   <= show ? pix : {PW{1'b0}};
            csync_q <= sog_en & (h_live | v_live);
        end
    end

    assert_black_R8: assert property (@(posedge clk) disable iff (rst)
        (blank || !de) |=> (pix_q == '0));

    assert_sog_off_R9: assert property (@(posedge clk) disable iff (rst)
        !sog_en |=> !csync_q);

endmodule

// File: rtl/sync_cond_stage.sv
module sync_cond_stage
    import sync_cond_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic             bus_sel,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             raw_hsync,
    input  logic             raw_vsync,
    input  logic             raw_de,
    input  logic [3*CW-1:0]  pix_in,
    output logic             hsync_out,
    output logic             vsync_out,
    output logic [3*CW-1:0]  pix_out,
    output logic             sync_on_rgb
);
    sync_cfg_t           cfg;
    logic                blank;
    logic [NUM_CH-1:0]   raw_v;
    logic [NUM_CH-1:0]   inv_v;
    logic [NUM_CH-1:0]   kill_v;
    logic [NUM_CH-1:0]   out_v;

    sync_cond_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .sel   (bus_sel),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg),
        .blank (blank)
    );

    always_comb begin
        raw_v[CH_H]  = raw_hsync;
        raw_v[CH_V]  = raw_vsync;
        inv_v[CH_H]  = cfg.h_inv;
        inv_v[CH_V]  = cfg.v_inv;
        kill_v[CH_H] = cfg.all_off | cfg.h_off;
        kill_v[CH_V] = cfg.all_off | cfg.v_off;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        sync_cond_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_v[i]),
            .inv   (inv_v[i]),
            .kill  (kill_v[i]),
            .out_q (out_v[i])
        );
    end

    assign hsync_out = out_v[CH_H];
    assign vsync_out = out_v[CH_V];

    sync_cond_video #(.CW(CW)) u_video (
        .clk     (clk),
        .rst     (rst),
        .de      (raw_de),
        .pix     (pix_in),
        .blank   (blank),
        .sog_en  (cfg.sog),
        .h_live  (raw_hsync & ~kill_v[CH_H]),
        .v_live  (raw_vsync & ~kill_v[CH_V]),
        .pix_q   (pix_out),
        .csync_q (sync_on_rgb)
    );

    assert_standby_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg.h_off && !cfg.all_off && !cfg.v_off && !cfg.v_inv)
            |=> (vsync_out == $past(raw_vsync)));

    assert_suspend_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.v_off && !cfg.all_off && !cfg.h_off && !cfg.h_inv)
            |=> (hsync_out == $past(raw_hsync)));

    assert_invert_R4: assert property (@(posedge clk) disable iff (rst)
        (!kill_v[CH_H] && cfg.h_inv) |=> (hsync_out == !$past(raw_hsync)));

endmodule

// File: tb/sim_sync_cond_stage.sv
module sim_sync_cond_stage;
    localparam int CW = 8;
    localparam int PW = 3 * CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic          bus_sel = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          raw_hsync = 1'b0;
    logic          raw_vsync = 1'b0;
    logic          raw_de = 1'b0;
    logic [PW-1:0] pix_in = '0;
    logic          hsync_out;
    logic          vsync_out;
    logic [PW-1:0] pix_out;
    logic          sync_on_rgb;

    always #5 clk = ~clk;

    sync_cond_stage #(.CW(CW)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .raw_hsync(raw_hsync), .raw_vsync(raw_vsync), .raw_de(raw_de),
        .pix_in(pix_in), .hsync_out(hsync_out), .vsync_out(vsync_out),
        .pix_out(pix_out), .sync_on_rgb(sync_on_rgb)
    );

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    string       cur_req = "R1";

    // behavioural reference model
    logic [7:0]    m_sc = '0, m_dc = '0;
    logic          e_hs = 0, e_vs = 0, e_cs = 0;
    logic [PW-1:0] e_pix = '0;

    always @(posedge clk) begin
        bit hk, vk;
        if (rst) begin
            m_sc = '0; m_dc = '0;
            e_hs = 0; e_vs = 0; e_cs = 0; e_pix = '0;
        end else begin
            hk = m_sc[1] | m_sc[5];
            vk = m_sc[1] | m_sc[6];
            e_hs = hk ? m_sc[3] : (raw_hsync ^ m_sc[3]);
            e_vs = vk ? m_sc[4] : (raw_vsync ^ m_sc[4]);
            e_pix = (m_dc[1] || !raw_de) ? '0 : pix_in;
            e_cs = m_sc[0] & ((raw_hsync & !hk) | (raw_vsync & !vk));
            if (bus_we) begin
                if (bus_sel) m_dc = bus_wdata & 8'h02;
                else         m_sc = bus_wdata & 8'h7B;
            end
        end
    end

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "hsync_out", 32'(hsync_out), 32'(e_hs));
        chk(req, "vsync_out", 32'(vsync_out), 32'(e_vs));
        chk(req, "pix_out", 32'(pix_out), 32'(e_pix));
        chk(req, "sync_on_rgb", 32'(sync_on_rgb), 32'(e_cs));
        chk(req, "bus_rdata", 32'(bus_rdata), bus_sel ? 32'(m_dc) : 32'(m_sc));
    endtask

    task automatic rand_inputs();
        logic [31:0] r;
        r = rnd();
        raw_hsync = r[17];
        raw_vsync = r[21];
        raw_de    = r[25];
        pix_in    = rnd() >> 4;
        bus_sel   = r[29];
    endtask

    // run n cycles with random video and a fixed register pair
    task automatic run_cfg(input string req, input logic [7:0] sc,
                           input logic [7:0] dc, input int n);
        cur_req = req;
        @(negedge clk);
        compare_all(req);
        bus_we = 1'b1; bus_sel = 1'b0; bus_wdata = sc;
        @(negedge clk);
        compare_all(req);
        bus_sel = 1'b1; bus_wdata = dc;
        @(negedge clk);
        compare_all(req);
        bus_we = 1'b0;
        for (int i = 0; i < n; i++) begin
            rand_inputs();
            @(negedge clk);
            compare_all(req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, driven inputs active during reset
        raw_hsync = 1; raw_vsync = 1; raw_de = 1; pix_in = 24'hABCDEF;
        repeat (3) @(negedge clk);
        bus_sel = 0;
        chk("R1", "hsync reset", 32'(hsync_out), 0);
        chk("R1", "vsync reset", 32'(vsync_out), 0);
        chk("R1", "pix reset", 32'(pix_out), 0);
        chk("R1", "csync reset", 32'(sync_on_rgb), 0);
        chk("R1", "sync reg reset", 32'(bus_rdata), 0);
        bus_sel = 1;
        #1 chk("R1", "disp reg reset", 32'(bus_rdata), 0);
        rst = 0;

        // R2: every bit of both registers, reserved bits must read 0
        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            compare_all("R2");
            bus_we = 1; bus_sel = i[0]; bus_wdata = 8'(rnd() >> 8);
            if (i < 2) bus_wdata = 8'hFF;
        end
        @(negedge clk); compare_all("R2");
        bus_we = 0; bus_sel = 0;
        #1 chk("R2", "sync reg mask", 32'(bus_rdata), 32'(m_sc));

        run_cfg("R3", 8'h00, 8'h00, 60);
        run_cfg("R4", 8'h08, 8'h00, 40);
        run_cfg("R4", 8'h10, 8'h00, 40);
        run_cfg("R4", 8'h18, 8'h00, 40);
        run_cfg("R5", 8'h20, 8'h02, 40);
        run_cfg("R5", 8'h38, 8'h02, 40);
        run_cfg("R6", 8'h40, 8'h02, 40);
        run_cfg("R6", 8'h58, 8'h02, 40);
        run_cfg("R7", 8'h02, 8'h02, 40);
        run_cfg("R7", 8'h1A, 8'h02, 40);
        run_cfg("R7", 8'h7B, 8'h02, 40);
        run_cfg("R8", 8'h00, 8'h02, 40);
        run_cfg("R8", 8'h00, 8'h00, 40);
        run_cfg("R9", 8'h01, 8'h00, 60);
        run_cfg("R9", 8'h21, 8'h00, 40);
        run_cfg("R9", 8'h49, 8'h00, 40);

        // R10: new configuration on every edge with toggling video
        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            rand_inputs();
            bus_we = 1'b1;
            bus_wdata = 8'(rnd() >> 11);
            @(negedge clk);
            compare_all("R10");
        end
        bus_we = 0;
        @(negedge clk); compare_all("R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule